// File: doc/BRIEF.md
# Smart card character framer

This block moves single characters across the half-duplex I/O line of an ISO 7816-style smart card. On the transmit side it takes a byte through a valid/ready handshake and puts one frame on the line: a start bit, eight data bits and a parity bit. After the parity bit it releases the line. On the receive side it watches the line for a start edge and samples each bit near the middle of its period. It rebuilds the byte, presents it through a valid/ready handshake, and flags a parity mismatch alongside it.

Bit timing comes from an external baud generator as a one-cycle `bitTick` pulse per bit time. The transmitter steps on those pulses. The receiver measures the spacing between them to find its mid-bit sampling point. Three static inputs select the character convention: bit order, inversion of the data bits, and the sense of the parity bit. Direct convention is all three low; inverse convention is all three high. On the line, a logic low is the active state (A) and a logic high is the idle or released state (Z).

Top module: `sc_char_framer`

## Requirements
- R1: After reset `lineTx` is 1, `txReady` is 1, `rxValid` is 0 and `rxParityErr` is 0.
- R2: A byte is accepted when `txValid` and `txReady` are both high at a clock edge. `txReady` then stays low until the frame ends. The start bit (0) appears at the first `bitTick` after acceptance. Each later tick moves to the next bit. At the tick that ends the parity bit, `lineTx` returns to 1 and `txReady` returns to 1. `lineTx` only changes in response to a tick.
- R3: With `msbFirst`=0 the data bits go out and come in with bit 0 first. With `msbFirst`=1 they go out and come in with bit 7 first.
- R4: With `invData`=1 every data bit on the line is the complement of the logical bit, in both directions. The start bit and the parity bit are never inverted.
- R5: The transmitted parity bit equals the XOR of the eight logical data bits, XORed with `oddParity`. Ones over the logical data plus parity are therefore even when `oddParity`=0.
- R6: A falling edge on `lineRx` starts a reception. Bits are sampled near mid-period, where the bit length is the measured clock spacing between `bitTick` pulses. The logical byte, rebuilt under R3 and R4, appears on `rxData` with `rxValid`=1.
- R7: `rxParityErr` is 1 together with `rxValid` exactly when the received parity bit differs from the value R5 gives for the received logical byte.
- R8: `rxValid`, `rxData` and `rxParityErr` hold until a cycle with `rxReady`=1, which clears `rxValid`. A byte completed while an earlier one is still unread replaces it.
- R9: If the line is high again when the start bit is sampled at mid-bit, the frame is dropped and `rxValid` stays 0.
- R10: With all three controls high, the line sequence low, high, high, low, low, low, low, low, low, high is byte 0x3F with good parity. With all three low, the sequence low, high, high, low, high, high, high, low, low, high is byte 0x3B with good parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | One-cycle pulse per bit time from the baud generator |
| msbFirst | input | 1 | 1: data bit 7 first; 0: data bit 0 first |
| invData | input | 1 | 1: data bits complemented on the line |
| oddParity | input | 1 | 1: parity bit complemented |
| txValid | input | 1 | Transmit byte offered |
| txData | input | 8 | Transmit byte |
| txReady | output | 1 | Transmitter idle and able to accept |
| lineTx | output | 1 | Line drive level, 1 = idle/released |
| lineRx | input | 1 | Line level as seen by the receiver |
| rxReady | input | 1 | Consumer takes the received byte |
| rxValid | output | 1 | Received byte present |
| rxData | output | 8 | Received logical byte |
| rxParityErr | output | 1 | Parity mismatch for the presented byte |

## Verification
Transmit and receive are independent machines that share one tick input. A transmit bit step and a receive sample or completion can therefore land in the same cycle. The bench provokes this by starting a transmission and driving a receive frame on `lineRx` in parallel. It then checks that the transmitted bit sequence and the received byte match what each would be alone. A second overlap is a new byte completing while the previous one is still unread. The bench holds `rxReady` low across two receptions and checks that the later byte replaces the earlier one.

// File: rtl/sc_framer_pkg.sv
package sc_framer_pkg;
  // Strobes issued by the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic txLoad;   // capture a new frame into the transmit shifter
    logic txBit;    // move the next line bit onto the output
    logic rxShift;  // take one data sample into the receive shifter
    logic rxDone;   // parity sample: publish the byte
  } frmStrobe_t;
endpackage

// File: rtl/sc_framer_ctrl.sv
module sc_framer_ctrl
  import sc_framer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int DEF_BIT_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       txValid,
  output logic       txReady,
  input  logic       rxLineSync,
  output frmStrobe_t strobe
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} txState_t;

  txState_t           txState;
  logic [IDX_W-1:0]   txCount;
  logic [CNT_W-1:0]   tickGap;
  logic [CNT_W-1:0]   bitLen;
  logic               rxBusy;
  logic               rxPrev;
  logic [IDX_W-1:0]   rxIdx;
  logic [CNT_W-1:0]   rxCnt;
  logic               rxSampleNow;

  // Transmit sequencing: wait for a tick, then one line bit per tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txCount <= '0;
    end else begin
      unique case (txState)
        TX_IDLE: if (txValid) txState <= TX_WAIT;
        TX_WAIT: if (bitTick) begin
          txState <= TX_SEND;
          txCount <= IDX_W'(1);
        end
        TX_SEND: if (bitTick) begin
          if (txCount == IDX_W'(FRAME_W)) txState <= TX_IDLE;
          else txCount <= txCount + IDX_W'(1);
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  assign txReady = (txState == TX_IDLE);

  // Bit length measured as the spacing between ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickGap <= '0;
      bitLen  <= CNT_W'(DEF_BIT_LEN);
    end else if (bitTick) begin
      bitLen  <= tickGap + CNT_W'(1);
      tickGap <= '0;
    end else if (tickGap != '1) begin
      tickGap <= tickGap + CNT_W'(1);
    end
  end

  // Receive sequencing: start edge, half-bit offset, then one sample per bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBusy <= 1'b0;
      rxPrev <= 1'b1;
      rxIdx  <= '0;
      rxCnt  <= '0;
    end else begin
      rxPrev <= rxLineSync;
      if (!rxBusy) begin
        if (rxPrev && !rxLineSync) begin
          rxBusy <= 1'b1;
          rxIdx  <= '0;
          rxCnt  <= bitLen >> 1;
        end
      end else if (rxCnt != '0) begin
        rxCnt <= rxCnt - CNT_W'(1);
      end else begin
        rxCnt <= bitLen - CNT_W'(1);
        if (rxIdx == '0 && rxLineSync) rxBusy <= 1'b0;
        else if (rxIdx == IDX_W'(FRAME_W - 1)) rxBusy <= 1'b0;
        else rxIdx <= rxIdx + IDX_W'(1);
      end
    end
  end

  assign rxSampleNow = rxBusy && (rxCnt == '0);

  always_comb begin
    strobe         = '0;
    strobe.txLoad  = txValid && txReady;
    strobe.txBit   = bitTick && (txState != TX_IDLE);
    strobe.rxShift = rxSampleNow && (rxIdx != '0) && (rxIdx != IDX_W'(FRAME_W - 1));
    strobe.rxDone  = rxSampleNow && (rxIdx == IDX_W'(FRAME_W - 1));
  end

  // R2
  tx_accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);
endmodule

// File: rtl/sc_framer_dp.sv
module sc_framer_dp
  import sc_framer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  frmStrobe_t        strobe,
  input  logic              msbFirst,
  input  logic              invData,
  input  logic              oddParity,
  input  logic [DATA_W-1:0] txData,
  output logic              lineTx,
  input  logic              lineRx,
  output logic              rxLineSync,
  input  logic              rxReady,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxParityErr
);
  localparam int FRAME_W = DATA_W + 2;

  logic [SYNC_STAGES-1:0] syncReg;
  logic [DATA_W-1:0]      txLineData, txReversed, txOrdered;
  logic [FRAME_W-1:0]     txFrame, txShift;
  logic [DATA_W-1:0]      rxShiftReg, rxReversed, rxLogical;
  logic                   rxExpPar;

  // Line synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], lineRx};
  end
  assign rxLineSync = syncReg[SYNC_STAGES-1];

  // Bit-order reversal networks
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rev
    assign txReversed[gi] = txLineData[DATA_W-1-gi];
    assign rxReversed[gi] = rxShiftReg[DATA_W-1-gi];
  end

  // Transmit frame: start at bit 0 (shifted out first), parity on top
  assign txLineData = txData ^ {DATA_W{invData}};
  assign txOrdered  = msbFirst ? txReversed : txLineData;
  assign txFrame    = {(^txData) ^ oddParity, txOrdered, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      lineTx  <= 1'b1;
    end else if (strobe.txLoad) begin
      txShift <= txFrame;
    end else if (strobe.txBit) begin
      lineTx  <= txShift[0];
      txShift <= {1'b1, txShift[FRAME_W-1:1]};
    end
  end

  // Receive assembly: first data sample ends in the top bit
  assign rxLogical = (msbFirst ? rxShiftReg : rxReversed) ^ {DATA_W{invData}};
  assign rxExpPar  = (^rxLogical) ^ oddParity;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftReg  <= '0;
      rxValid     <= 1'b0;
      rxData      <= '0;
      rxParityErr <= 1'b0;
    end else begin
      if (strobe.rxShift) rxShiftReg <= {rxShiftReg[DATA_W-2:0], rxLineSync};
      if (strobe.rxDone) begin
        rxValid     <= 1'b1;
        rxData      <= rxLogical;
        rxParityErr <= (rxLineSync != rxExpPar);
      end else if (rxReady) begin
        rxValid     <= 1'b0;
        rxParityErr <= 1'b0;
      end
    end
  end

  // R7
  rx_err_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxParityErr |-> rxValid);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !strobe.rxDone) |=> (rxValid && $stable(rxData)));
endmodule

// File: rtl/sc_char_framer.sv
module sc_char_framer
  import sc_framer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int DEF_BIT_LEN = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              msbFirst,
  input  logic              invData,
  input  logic              oddParity,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txReady,
  output logic              lineTx,
  input  logic              lineRx,
  input  logic              rxReady,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxParityErr
);
  frmStrobe_t strobe;
  logic       rxLineSync;

  sc_framer_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DEF_BIT_LEN(DEF_BIT_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txValid(txValid),
    .txReady(txReady), .rxLineSync(rxLineSync), .strobe(strobe)
  );

  sc_framer_dp #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .msbFirst(msbFirst),
    .invData(invData), .oddParity(oddParity), .txData(txData),
    .lineTx(lineTx), .lineRx(lineRx), .rxLineSync(rxLineSync),
    .rxReady(rxReady), .rxValid(rxValid), .rxData(rxData),
    .rxParityErr(rxParityErr)
  );

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> lineTx);

  // R2
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineTx) |-> $past(bitTick));
endmodule

// File: tb/sim_sc_char_framer.sv
`timescale 1ns/1ps
module sim_sc_char_framer;
  localparam int BIT_CLKS = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic       msbFirst = 1'b0, invData = 1'b0, oddParity = 1'b0;
  logic       txValid = 1'b0;
  logic [7:0] txData = '0;
  logic       txReady, lineTx, rxValid, rxParityErr;
  logic       lineRx = 1'b1;
  logic       rxReady = 1'b0;
  logic [7:0] rxData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sc_char_framer u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .msbFirst(msbFirst),
    .invData(invData), .oddParity(oddParity), .txValid(txValid),
    .txData(txData), .txReady(txReady), .lineTx(lineTx), .lineRx(lineRx),
    .rxReady(rxReady), .rxValid(rxValid), .rxData(rxData),
    .rxParityErr(rxParityErr)
  );

  // Baud generator model: one-cycle tick every BIT_CLKS clocks
  initial begin
    forever begin
      repeat (BIT_CLKS - 1) @(posedge clk);
      #1 bitTick = 1'b1;
      @(posedge clk);
      #1 bitTick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected line bits, index 0 = start bit, 1..8 data, 9 parity
  function automatic logic [9:0] expLine(input logic [7:0] b, input logic msb,
                                         input logic inv, input logic odd,
                                         input logic badPar);
    logic [9:0] l;
    l[0] = 1'b0;
    for (int k = 1; k <= 8; k++) l[k] = b[msb ? 8 - k : k - 1] ^ inv;
    l[9] = (^b) ^ odd ^ badPar;
    return l;
  endfunction

  task automatic setCfg(input logic m, input logic i, input logic o);
    @(negedge clk);
    msbFirst = m; invData = i; oddParity = o;
  endtask

  // R2: transmit one byte and compare the captured line bits
  task automatic sendTx(input logic [7:0] b, input logic [9:0] exp, input string req);
    logic [9:0] got;
    int waitCnt;
    @(negedge clk);
    txData = b; txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
    chk(txReady == 1'b0, {req, " busy after accept (R2)"}, txReady, 0);
    waitCnt = 0;
    while (lineTx && waitCnt < 100) begin @(negedge clk); waitCnt++; end
    repeat (BIT_CLKS / 2) @(negedge clk);
    got[0] = lineTx;
    for (int k = 1; k < 10; k++) begin
      repeat (BIT_CLKS) @(negedge clk);
      got[k] = lineTx;
    end
    chk(got == exp, req, got, exp);
    repeat (BIT_CLKS) @(negedge clk);
    chk(lineTx == 1'b1 && txReady == 1'b1, "R2 released after parity",
        {lineTx, txReady}, 2'b11);
  endtask

  task automatic driveRx(input logic [9:0] l);
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      lineRx = l[k];
      repeat (BIT_CLKS) @(negedge clk);
    end
    lineRx = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic checkRx(input logic [7:0] b, input logic err, input string req);
    chk(rxValid == 1'b1, {req, " valid"}, rxValid, 1);
    chk(rxData == b, {req, " data"}, rxData, b);
    chk(rxParityErr == err, {req, " parity flag (R7)"}, rxParityErr, err);
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
    chk(rxValid == 1'b0, "R8 cleared by rxReady", rxValid, 0);
  endtask

  task automatic testReset();
    chk(lineTx == 1'b1, "R1 lineTx", lineTx, 1);
    chk(txReady == 1'b1, "R1 txReady", txReady, 1);
    chk(rxValid == 1'b0, "R1 rxValid", rxValid, 0);
    chk(rxParityErr == 1'b0, "R1 rxParityErr", rxParityErr, 0);
  endtask

  task automatic testTxConventions();
    setCfg(0, 0, 0);
    sendTx(8'hA5, expLine(8'hA5, 0, 0, 0, 0), "R3 lsb-first tx");
    setCfg(1, 0, 0);
    sendTx(8'h1C, expLine(8'h1C, 1, 0, 0, 0), "R3 msb-first tx");
    setCfg(0, 1, 0);
    sendTx(8'h3C, expLine(8'h3C, 0, 1, 0, 0), "R4 inverted data tx");
    setCfg(0, 0, 1);
    sendTx(8'h07, expLine(8'h07, 0, 0, 1, 0), "R5 odd parity tx");
    setCfg(1, 1, 1);
    sendTx(8'h3F, 10'h206, "R10 inverse 0x3F tx");
    setCfg(0, 0, 0);
    sendTx(8'h3B, 10'h276, "R10 direct 0x3B tx");
  endtask

  task automatic testTxBusy();
    setCfg(0, 0, 0);
    fork
      sendTx(8'h5A, expLine(8'h5A, 0, 0, 0, 0), "R2 frame while offered");
      begin
        repeat (40) @(negedge clk);
        chk(txReady == 1'b0, "R2 not ready mid-frame", txReady, 0);
      end
    join
  endtask

  task automatic testRxConventions();
    setCfg(0, 0, 0);
    driveRx(expLine(8'hC3, 0, 0, 0, 0)); checkRx(8'hC3, 0, "R6 rx direct");
    setCfg(1, 0, 0);
    driveRx(expLine(8'h81, 1, 0, 0, 0)); checkRx(8'h81, 0, "R3 rx msb-first");
    setCfg(0, 1, 0);
    driveRx(expLine(8'h6E, 0, 1, 0, 0)); checkRx(8'h6E, 0, "R4 rx inverted");
    setCfg(0, 0, 1);
    driveRx(expLine(8'h55, 0, 0, 1, 0)); checkRx(8'h55, 0, "R5 rx odd parity");
    setCfg(0, 0, 0);
    driveRx(expLine(8'h12, 0, 0, 0, 1)); checkRx(8'h12, 1, "R7 rx bad parity");
    setCfg(1, 1, 1);
    driveRx(expLine(8'hF0, 1, 1, 1, 1)); checkRx(8'hF0, 1, "R7 rx bad parity inverse");
    driveRx(10'h206); checkRx(8'h3F, 0, "R10 rx inverse");
    setCfg(0, 0, 0);
    driveRx(10'h276); checkRx(8'h3B, 0, "R10 rx direct");
  endtask

  task automatic testRxHold();
    setCfg(0, 0, 0);
    driveRx(expLine(8'h44, 0, 0, 0, 0));
    repeat (40) @(negedge clk);
    chk(rxValid == 1'b1 && rxData == 8'h44, "R8 held without rxReady", rxData, 8'h44);
    driveRx(expLine(8'h99, 0, 0, 0, 1));
    checkRx(8'h99, 1, "R8 replaced by later byte");
  endtask

  task automatic testRxGlitch();
    @(negedge clk);
    lineRx = 1'b0;
    repeat (4) @(negedge clk);
    lineRx = 1'b1;
    repeat (20 * BIT_CLKS) @(negedge clk);
    chk(rxValid == 1'b0, "R9 glitch dropped", rxValid, 0);
    driveRx(expLine(8'h2D, 0, 0, 0, 0)); checkRx(8'h2D, 0, "R9 recovers after glitch");
  endtask

  task automatic testOverlap();
    setCfg(1, 1, 1);
    fork
      sendTx(8'hB7, expLine(8'hB7, 1, 1, 1, 0), "R2 tx during rx");
      begin
        repeat (5) @(negedge clk);
        driveRx(expLine(8'h68, 1, 1, 1, 0));
      end
    join
    checkRx(8'h68, 0, "R6 rx during tx");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (4 * BIT_CLKS) @(negedge clk);
    testReset();
    testTxConventions();
    testTxBusy();
    testRxConventions();
    testRxHold();
    testRxGlitch();
    testOverlap();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule